// File: doc/BRIEF.md
# UART Modem Control Loopback

This block holds a UART's control register and produces the modem-status flags seen by software. In normal operation the four modem status flags (clear-to-send, data-set-ready, carrier-detect, ring-indicate) follow the external modem input pins. The pins pass through a two-flop synchronizer and then a flag register. When software sets the loopback-enable bit in the control register, the flags are instead driven from the control register's own modem outputs. The mapping is fixed: Out2 drives ring-indicate, Out1 drives carrier-detect, request-to-send drives clear-to-send, and data-terminal-ready drives data-set-ready.

Every control write that leaves loopback enabled rebuilds the four modem-status interrupt bits. The block emits a one-cycle clear of all four bits, together with a set mask for each looped flag that is high. The interrupt controller beside the block applies the clear first and then the set. Software writes to the flag register go through the same write port and are discarded. Flow-control-driven changes of clear-to-send and request-to-send are handled elsewhere.

Top module: `uart_modem_loopback`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 loads `wr_data` into `ctrl_reg`, which shows the new value one clock after the write edge. Reset clears `ctrl_reg` to 0.
- R2: While loopback is on (control bit 7), `flags` bit 8 (ring-indicate) equals control bit 13 (Out2), and `flags` bit 2 (carrier-detect) equals control bit 12 (Out1).
- R3: While loopback is on, `flags` bit 0 (clear-to-send) equals control bit 11 (request-to-send), and `flags` bit 1 (data-set-ready) equals control bit 10 (data-terminal-ready).
- R4: The loopback mapping appears on `flags` one clock after the same control write that sets bit 7, whatever the external pins are doing in that cycle.
- R5: A control write with bit 7 set pulses `ms_clr` high for exactly one cycle, with the same timing as R4. In that same cycle, `ms_set` carries the looped flags in the bit order [0]=ring-indicate, [1]=clear-to-send, [2]=carrier-detect, [3]=data-set-ready. Outside such a cycle, both `ms_clr` and `ms_set` are 0.
- R6: A control write with bit 7 clear produces no `ms_clr` or `ms_set` pulse. One clock after that write, `flags` returns to the synchronized pin values.
- R7: A write with `wr_sel`=1 (the flag register) changes neither `ctrl_reg` nor `flags`, and produces no interrupt pulse.
- R8: With loopback off, a pin change reaches `flags` three clocks later (two synchronizer flops plus the flag register). It has not yet appeared after two clocks.
- R9: After reset, `flags`, `ms_clr` and `ms_set` are 0. `flags` bits other than 0, 1, 2 and 8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = flag register (ignored) |
| wr_data | input | 16 | Write data |
| pin_cts | input | 1 | External clear-to-send input, active high, asynchronous |
| pin_dsr | input | 1 | External data-set-ready input, active high, asynchronous |
| pin_dcd | input | 1 | External carrier-detect input, active high, asynchronous |
| pin_ri | input | 1 | External ring-indicate input, active high, asynchronous |
| ctrl_reg | output | 16 | Current control register value, for the rest of the UART |
| flags | output | 16 | Modem-status flags (CTS bit 0, DSR bit 1, DCD bit 2, RI bit 8) |
| ms_clr | output | 1 | One-cycle pulse: clear all four modem-status interrupt bits |
| ms_set | output | 4 | Modem-status interrupt bits to set, valid when `ms_clr` is high |

## Verification
A loopback-enabling control write and an external pin change can land in the same cycle. Both compete for the flag register. The bench provokes this by toggling the pins on the same edge as the enabling write. It then judges that `flags` shows the control-bit mapping on the next cycle and keeps it three cycles later, after the pin change would have cleared the synchronizer. The opposite race, a write that disables loopback while the pins hold new values, is judged by checking that `flags` takes the synchronized pins one cycle after the write.

// File: rtl/uart_mlb_pkg.sv
package uart_mlb_pkg;
  parameter int unsigned CTRL_W = 16;
  parameter int unsigned FLAG_W = 16;
  parameter int unsigned MDM_N  = 4;

  // control bit positions
  localparam int unsigned C_LBE  = 7;
  localparam int unsigned C_DTR  = 10;
  localparam int unsigned C_RTS  = 11;
  localparam int unsigned C_OUT1 = 12;
  localparam int unsigned C_OUT2 = 13;

  // flag bit positions
  localparam int unsigned F_CTS = 0;
  localparam int unsigned F_DSR = 1;
  localparam int unsigned F_DCD = 2;
  localparam int unsigned F_RI  = 8;

  typedef struct packed {
    logic ri;
    logic dcd;
    logic cts;
    logic dsr;
  } modem_t;

  // control outputs -> looped status inputs
  function automatic modem_t loop_map(input logic [CTRL_W-1:0] c);
    modem_t m;
    m.ri  = c[C_OUT2];
    m.dcd = c[C_OUT1];
    m.cts = c[C_RTS];
    m.dsr = c[C_DTR];
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] pack_flags(input modem_t m);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[F_CTS] = m.cts;
    f[F_DSR] = m.dsr;
    f[F_DCD] = m.dcd;
    f[F_RI]  = m.ri;
    return f;
  endfunction

  // interrupt bit order: [0]=RI [1]=CTS [2]=DCD [3]=DSR
  function automatic logic [MDM_N-1:0] irq_bits(input modem_t m);
    return {m.dsr, m.dcd, m.cts, m.ri};
  endfunction
endpackage

// File: rtl/mlb_sync.sv
module mlb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mlb_ctrl_reg.sv
module mlb_ctrl_reg
  import uart_mlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] ctrl_next,
  output logic              ctrl_wr_evt,
  output logic              lb_wr_evt,
  output logic              flag_wr_evt
);
  assign ctrl_wr_evt = wr_en && !wr_sel;
  assign flag_wr_evt = wr_en && wr_sel;
  assign ctrl_next   = ctrl_wr_evt ? wr_data : ctrl_q;
  assign lb_wr_evt   = ctrl_wr_evt && wr_data[C_LBE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_next;
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (ctrl_q == $past(wr_data)));

  a_r7_flag_write_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_evt |=> $stable(ctrl_q));
endmodule

// File: rtl/mlb_flag_sel.sv
module mlb_flag_sel
  import uart_mlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [CTRL_W-1:0] ctrl_next,
  input  logic              ctrl_wr_evt,
  input  logic              lb_wr_evt,
  input  modem_t            pins_sync,
  output logic [FLAG_W-1:0] flags_q,
  output logic              ms_clr,
  output logic [MDM_N-1:0]  ms_set
);
  modem_t looped;
  modem_t chosen;

  assign looped = loop_map(ctrl_next);
  assign chosen = ctrl_next[C_LBE] ? looped : pins_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ms_clr  <= 1'b0;
      ms_set  <= '0;
    end else begin
      flags_q <= pack_flags(chosen);
      ms_clr  <= lb_wr_evt;
      ms_set  <= lb_wr_evt ? irq_bits(looped) : '0;
    end
  end

  a_r2_ri_dcd_follow: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr_evt |=> (flags_q[F_RI] == $past(ctrl_next[C_OUT2]) &&
                   flags_q[F_DCD] == $past(ctrl_next[C_OUT1])));

  a_r3_cts_dsr_follow: assert property (@(posedge clk) disable iff (!rst_n)
    lb_wr_evt |=> (flags_q[F_CTS] == $past(ctrl_next[C_RTS]) &&
                   flags_q[F_DSR] == $past(ctrl_next[C_DTR])));

  a_r5_set_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_set != '0) |-> ms_clr);

  a_r5_set_matches_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ms_clr |-> (ms_set == {flags_q[F_DSR], flags_q[F_DCD], flags_q[F_CTS], flags_q[F_RI]}));

  a_r6_clear_only_after_lb_write: assert property (@(posedge clk) disable iff (!rst_n)
    ms_clr |-> $past(lb_wr_evt));

  a_r7_loop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_LBE] && !ctrl_wr_evt) |=> $stable(flags_q));
endmodule

// File: rtl/uart_modem_loopback.sv
module uart_modem_loopback
  import uart_mlb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              pin_dcd,
  input  logic              pin_ri,
  output logic [CTRL_W-1:0] ctrl_reg,
  output logic [FLAG_W-1:0] flags,
  output logic              ms_clr,
  output logic [MDM_N-1:0]  ms_set
);
  logic [CTRL_W-1:0] ctrl_next;
  logic              ctrl_wr_evt;
  logic              lb_wr_evt;
  logic              flag_wr_evt;
  modem_t            pins_raw;
  modem_t            pins_sync;

  assign pins_raw = '{ri: pin_ri, dcd: pin_dcd, cts: pin_cts, dsr: pin_dsr};

  mlb_sync #(.WIDTH(MDM_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_raw),
    .d_sync  (pins_sync)
  );

  mlb_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .ctrl_q      (ctrl_reg),
    .ctrl_next   (ctrl_next),
    .ctrl_wr_evt (ctrl_wr_evt),
    .lb_wr_evt   (lb_wr_evt),
    .flag_wr_evt (flag_wr_evt)
  );

  mlb_flag_sel u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_q      (ctrl_reg),
    .ctrl_next   (ctrl_next),
    .ctrl_wr_evt (ctrl_wr_evt),
    .lb_wr_evt   (lb_wr_evt),
    .pins_sync   (pins_sync),
    .flags_q     (flags),
    .ms_clr      (ms_clr),
    .ms_set      (ms_set)
  );

  a_r9_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_wr_evt |=> (!ms_clr && ms_set == '0));

  a_r7_flag_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_evt |=> !ms_clr);
endmodule

// File: tb/tb_uart_modem_loopback.sv
module tb_uart_modem_loopback;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pin_cts = 1'b0, pin_dsr = 1'b0, pin_dcd = 1'b0, pin_ri = 1'b0;
  logic [15:0] ctrl_reg;
  logic [15:0] flags;
  logic        ms_clr;
  logic [3:0]  ms_set;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_modem_loopback dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_dcd(pin_dcd), .pin_ri(pin_ri),
    .ctrl_reg(ctrl_reg), .flags(flags), .ms_clr(ms_clr), .ms_set(ms_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // flags expected in loopback: CTS@0<-c11, DSR@1<-c10, DCD@2<-c12, RI@8<-c13
  function automatic logic [15:0] want_flags(input logic [15:0] c);
    return (16'(c[13]) << 8) | (16'(c[12]) << 2) | (16'(c[10]) << 1) | 16'(c[11]);
  endfunction
  // set mask: [0]=RI [1]=CTS [2]=DCD [3]=DSR
  function automatic logic [3:0] want_set(input logic [15:0] c);
    return {c[10], c[12], c[11], c[13]};
  endfunction
  function automatic logic [15:0] pin_flags();
    return (16'(pin_ri) << 8) | (16'(pin_dcd) << 2) | (16'(pin_dsr) << 1) | 16'(pin_cts);
  endfunction

  task automatic do_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset flags", 32'(flags), 0);
    chk("R9 reset ms_clr", 32'(ms_clr), 0);
    chk("R9 reset ms_set", 32'(ms_set), 0);
    chk("R1 reset ctrl", 32'(ctrl_reg), 0);
  endtask

  task automatic t_pins();
    @(negedge clk);
    pin_cts = 1'b1; pin_ri = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 not yet after two clocks", 32'(flags), 0);
    @(negedge clk);
    chk("R8 pins after three clocks", 32'(flags), 32'h0101);
    chk("R9 no pulse from pins", 32'({ms_clr, ms_set}), 0);
  endtask

  task automatic t_loop(input logic [15:0] c);
    do_write(1'b0, c);
    chk("R1 ctrl capture", 32'(ctrl_reg), 32'(c));
    chk("R2 RI/DCD loop", 32'(flags & 16'h0104), 32'(want_flags(c) & 16'h0104));
    chk("R3 CTS/DSR loop", 32'(flags & 16'h0003), 32'(want_flags(c) & 16'h0003));
    chk("R4 same-write effect", 32'(flags), 32'(want_flags(c)));
    chk("R5 ms_clr pulse", 32'(ms_clr), 1);
    chk("R5 ms_set mask", 32'(ms_set), 32'(want_set(c)));
    @(negedge clk);
    chk("R5 pulse one cycle", 32'({ms_clr, ms_set}), 0);
    chk("R9 reserved flag bits", 32'(flags & 16'hFEF8), 0);
  endtask

  task automatic t_flag_write();
    logic [15:0] f0, c0;
    f0 = flags; c0 = ctrl_reg;
    do_write(1'b1, 16'hFFFF);
    chk("R7 flags unchanged", 32'(flags), 32'(f0));
    chk("R7 ctrl unchanged", 32'(ctrl_reg), 32'(c0));
    chk("R7 no pulse", 32'({ms_clr, ms_set}), 0);
  endtask

  task automatic t_disable();
    do_write(1'b0, 16'h3C00);
    chk("R1 ctrl capture off", 32'(ctrl_reg), 32'h3C00);
    chk("R6 no pulse on disable", 32'({ms_clr, ms_set}), 0);
    chk("R6 flags back to pins", 32'(flags), 32'(pin_flags()));
  endtask

  task automatic t_race();
    // enabling write and pin change on the same edge
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h1880;
    pin_cts = 1'b0; pin_ri = 1'b0; pin_dsr = 1'b1; pin_dcd = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R4 race write wins", 32'(flags), 32'h0005);
    chk("R5 race set mask", 32'(ms_set), 32'b0110);
    repeat (3) @(negedge clk);
    chk("R4 race holds after sync", 32'(flags), 32'h0005);
    do_write(1'b0, 16'h0000);
    chk("R6 race return to pins", 32'(flags), 32'h0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pins();
    do_write(1'b1, 16'h0000);
    chk("R7 flag write no effect off", 32'(ctrl_reg), 0);
    chk("R7 flags keep pins", 32'(flags), 32'h0101);
    t_loop(16'h0080);
    t_flag_write();
    t_loop(16'h3C80);
    t_loop(16'h2480);
    t_loop(16'h1880);
    t_flag_write();
    t_disable();
    t_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule